// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Accumulator

This unit sits beside an integer pipeline and performs the long-latency arithmetic: 32-bit signed and unsigned multiplication into a 64-bit result pair (`hi`, `lo`), and multiply-accumulate and multiply-subtract into that pair. It also offers a three-operand multiply whose low product half goes straight to a register-file write port, and a restoring divider that shortens its run when the dividend is small. Moves into `hi` and `lo` are single-cycle writes. Reading them needs no operation, because both registers are always visible on output ports.

The pipeline presents an operation with `in_valid`, `in_op`, `in_a` and `in_b`. The unit accepts it on a clock edge where `in_valid` is high and `busy` is low. Multiplies run for a fixed `MUL_LAT` cycles. A divide runs for 9, 17, 25 or 32 cycles, depending on how many of the dividend's upper bits carry no information. If an operation is presented while the unit is busy, `stall` rises and the operation waits.

Top module: `mdu_core`

## Requirements
- R1: After reset, `hi` and `lo` are zero and `busy`, `stall` and `rd_valid` are low.
- R2: Opcode 0 (signed) and opcode 1 (unsigned) load `{hi,lo}` with the full 64-bit product of `in_a` and `in_b`. The write happens `MUL_LAT` (default 2) clock edges after the accepting edge, and `busy` is high for exactly those `MUL_LAT` cycles.
- R3: Opcode 6 drives the low 32 bits of the product onto `rd_data`, with a one-cycle `rd_valid` pulse at the cycle where `busy` falls. `hi` and `lo` are left unchanged.
- R4: Opcode 2 (signed) and opcode 3 (unsigned) add the 64-bit product to `{hi,lo}` modulo 2^64, with the same timing as R2.
- R5: Opcode 4 (signed) and opcode 5 (unsigned) subtract the 64-bit product from `{hi,lo}` modulo 2^64, with the same timing as R2.
- R6: Opcode 7 (signed) and opcode 8 (unsigned) divide `in_a` by `in_b`. `lo` receives the quotient truncated toward zero and `hi` the remainder, which for signed divides has the sign of the dividend.
- R7: A divide keeps `busy` high for exactly N cycles and writes at the Nth edge. N is 9 if the dividend's top 24 bits are redundant, otherwise 17 if its top 16 bits are redundant, otherwise 25 if its top 8 bits are redundant, and otherwise 32. Redundant means equal to the sign bit below them for signed divides, and zero for unsigned divides.
- R8: A divide by zero keeps the timing of R7 and leaves `lo` all ones and `hi` equal to the dividend.
- R9: `stall` equals `in_valid` while `busy` is high. An operation offered during a busy period is not accepted until the cycle after `busy` falls, and it does not disturb the running result.
- R10: Opcode 9 writes `in_a` to `hi` and opcode 10 writes `in_a` to `lo` at the accepting edge. Neither raises `busy`.
- R11: Opcodes 11 to 15 are ignored: `hi`, `lo`, `busy` and `rd_valid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_op | input | 4 | Operation code (see requirements) |
| in_a | input | W | First operand / dividend / move data |
| in_b | input | W | Second operand / divisor |
| busy | output | 1 | Multiply or divide in progress |
| stall | output | 1 | Offered operation must be held |
| hi | output | W | Upper result register (remainder after divide) |
| lo | output | W | Lower result register (quotient after divide) |
| rd_valid | output | 1 | Register-file result strobe for opcode 6 |
| rd_data | output | W | Register-file result for opcode 6 |

## Verification
The bench drives inputs on falling edges and samples on falling edges. After each accepting edge it counts the falling edges on which `busy` is high. It then compares that count with `MUL_LAT` for multiply-type operations, or with the iteration count for divides. The iteration count is worked out in the bench from whether the dividend fits in 8, 16 or 24 bits. `hi`, `lo`, `rd_valid` and `rd_data` are checked at the first falling edge with `busy` low, which is the cycle the result becomes visible. Moves and ignored opcodes have no busy period, so they are checked at the falling edge that follows the accepting edge. In the stall test, the result of the running divide is checked before the held move is accepted, and the move's effect is checked one cycle later.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MULS  = 4'd0,
    OP_MULU  = 4'd1,
    OP_MACS  = 4'd2,
    OP_MACU  = 4'd3,
    OP_MSBS  = 4'd4,
    OP_MSBU  = 4'd5,
    OP_MUL3  = 4'd6,
    OP_DIVS  = 4'd7,
    OP_DIVU  = 4'd8,
    OP_SETHI = 4'd9,
    OP_SETLO = 4'd10
  } mdu_op_e;

  // where a finished product goes
  typedef enum logic [1:0] {
    DST_LOAD,
    DST_ADD,
    DST_SUB,
    DST_RF
  } mul_dst_e;
endpackage

// File: rtl/mdu_mult.sv
module mdu_mult import mdu_pkg::*; #(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sgn,
  input  mul_dst_e      dst,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic          active,
  output logic          done,
  output mul_dst_e      dst_q,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  // full-width product: extend both operands, keep the low 2W bits
  function automatic logic [PW-1:0] mul_full(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic s);
    logic [PW-1:0] xe, ye;
    xe = s ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
    ye = s ? {{W{y[W-1]}}, y} : {{W{1'b0}}, y};
    return xe * ye;
  endfunction

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      prod   <= '0;
      dst_q  <= DST_LOAD;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(LAT - 1);
      prod   <= mul_full(a, b, sgn);
      dst_q  <= dst;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign done = active && (cnt == '0);

  // R2: a fresh multiply always starts with the full latency window loaded
  a_r2_lat_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt == CW'(LAT - 1)));

  // R2: a running multiply ignores new start requests
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> active);
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dnd,
  input  logic [W-1:0] dvs,
  output logic         active,
  output logic         done,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);
  localparam int Q1 = W / 4;
  localparam int Q2 = W / 2;
  localparam int Q3 = 3 * W / 4;

  // top n bits all equal the reference bit (the sign below them, or zero)
  function automatic logic top_redundant(input logic [W-1:0] x, input int n,
                                         input logic s);
    logic ref_b, ok;
    ref_b = s ? x[W-1-n] : 1'b0;
    ok = 1'b1;
    for (int i = 0; i < W; i++)
      if (i >= W - n && x[i] != ref_b) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [CW-1:0] iter_count(input logic [W-1:0] x,
                                               input logic s);
    if (top_redundant(x, Q3, s))      return CW'(Q1 + 1);
    else if (top_redundant(x, Q2, s)) return CW'(Q2 + 1);
    else if (top_redundant(x, Q1, s)) return CW'(Q3 + 1);
    else                              return CW'(W);
  endfunction

  function automatic logic [W-1:0] magn(input logic [W-1:0] x, input logic s);
    return (s && x[W-1]) ? -x : x;
  endfunction

  logic [W-1:0]  rem, quo, dvs_m, dnd_raw;
  logic [CW-1:0] cnt;
  logic          neg_q, neg_r, dz;

  logic [CW-1:0] n_start;
  logic [W-1:0]  mag_start;
  logic [W:0]    trial;
  logic          ge;
  logic [W-1:0]  rem_n, quo_n;

  always_comb begin
    n_start   = iter_count(dnd, sgn);
    mag_start = magn(dnd, sgn) << (W - int'(n_start));
    trial     = {rem, quo[W-1]};
    ge        = trial >= {1'b0, dvs_m};
    rem_n     = ge ? W'(trial - {1'b0, dvs_m}) : trial[W-1:0];
    quo_n     = {quo[W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      rem     <= '0;
      quo     <= '0;
      dvs_m   <= '0;
      dnd_raw <= '0;
      neg_q   <= 1'b0;
      neg_r   <= 1'b0;
      dz      <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      cnt     <= n_start;
      rem     <= '0;
      quo     <= mag_start;
      dvs_m   <= magn(dvs, sgn);
      dnd_raw <= dnd;
      neg_q   <= sgn && (dnd[W-1] ^ dvs[W-1]);
      neg_r   <= sgn && dnd[W-1];
      dz      <= (dvs == '0);
    end else if (active) begin
      rem <= rem_n;
      quo <= quo_n;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) active <= 1'b0;
    end
  end

  assign done  = active && (cnt == CW'(1));
  assign quo_o = dz ? '1 : (neg_q ? -quo_n : quo_n);
  assign rem_o = dz ? dnd_raw : (neg_r ? -rem_n : rem_n);

  // R7: the iteration count chosen at start is one of the four lengths
  a_r7_iter_choice: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt == CW'(W) || cnt == CW'(Q3 + 1) ||
                       cnt == CW'(Q2 + 1) || cnt == CW'(Q1 + 1)));

  // R6: restoring invariant, the partial remainder stays below the divisor
  a_r6_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dvs_m != '0) |-> (rem < dvs_m));
endmodule

// File: rtl/mdu_core.sv
module mdu_core import mdu_pkg::*; #(
  parameter int W       = 32,
  parameter int MUL_LAT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] in_op,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           busy,
  output logic           stall,
  output logic [W-1:0]   hi,
  output logic [W-1:0]   lo,
  output logic           rd_valid,
  output logic [W-1:0]   rd_data
);
  localparam int PW = 2 * W;

  mdu_op_e  op;
  logic     accept;
  logic     mul_start, div_start, set_hi, set_lo, m_sgn, d_sgn;
  mul_dst_e m_dst;

  logic          mul_active, mul_done;
  mul_dst_e      mul_dst;
  logic [PW-1:0] mul_prod;
  logic          div_active, div_done;
  logic [W-1:0]  div_quo, div_rem;

  logic [W-1:0] hi_q, lo_q, rd_q;
  logic         rdv_q;

  assign op     = mdu_op_e'(in_op);
  assign busy   = mul_active || div_active;
  assign accept = in_valid && !busy;
  assign stall  = in_valid && busy;

  always_comb begin
    mul_start = 1'b0;
    div_start = 1'b0;
    set_hi    = 1'b0;
    set_lo    = 1'b0;
    m_sgn     = 1'b0;
    d_sgn     = 1'b0;
    m_dst     = DST_LOAD;
    if (accept) begin
      case (op)
        OP_MULS:  begin mul_start = 1'b1; m_sgn = 1'b1; end
        OP_MULU:  begin mul_start = 1'b1; end
        OP_MACS:  begin mul_start = 1'b1; m_sgn = 1'b1; m_dst = DST_ADD; end
        OP_MACU:  begin mul_start = 1'b1; m_dst = DST_ADD; end
        OP_MSBS:  begin mul_start = 1'b1; m_sgn = 1'b1; m_dst = DST_SUB; end
        OP_MSBU:  begin mul_start = 1'b1; m_dst = DST_SUB; end
        OP_MUL3:  begin mul_start = 1'b1; m_sgn = 1'b1; m_dst = DST_RF; end
        OP_DIVS:  begin div_start = 1'b1; d_sgn = 1'b1; end
        OP_DIVU:  begin div_start = 1'b1; end
        OP_SETHI: set_hi = 1'b1;
        OP_SETLO: set_lo = 1'b1;
        default:  ;
      endcase
    end
  end

  mdu_mult #(.W(W), .LAT(MUL_LAT)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (mul_start),
    .sgn    (m_sgn),
    .dst    (m_dst),
    .a      (in_a),
    .b      (in_b),
    .active (mul_active),
    .done   (mul_done),
    .dst_q  (mul_dst),
    .prod   (mul_prod)
  );

  mdu_div #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (div_start),
    .sgn    (d_sgn),
    .dnd    (in_a),
    .dvs    (in_b),
    .active (div_active),
    .done   (div_done),
    .quo_o  (div_quo),
    .rem_o  (div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= mul_done && (mul_dst == DST_RF);
      if (mul_done) begin
        case (mul_dst)
          DST_LOAD: {hi_q, lo_q} <= mul_prod;
          DST_ADD:  {hi_q, lo_q} <= {hi_q, lo_q} + mul_prod;
          DST_SUB:  {hi_q, lo_q} <= {hi_q, lo_q} - mul_prod;
          DST_RF:   rd_q <= mul_prod[W-1:0];
          default:  ;
        endcase
      end else if (div_done) begin
        hi_q <= div_rem;
        lo_q <= div_quo;
      end else begin
        if (set_hi) hi_q <= in_a;
        if (set_lo) lo_q <= in_a;
      end
    end
  end

  assign hi       = hi_q;
  assign lo       = lo_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rd_q;

  // R2 / R7: busy falls right after the edge that writes the result
  a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_done || div_done) |=> !busy);

  // R3: the register-file multiply leaves the result pair untouched
  a_r3_hilo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_done && mul_dst == DST_RF) |=> ($stable(hi_q) && $stable(lo_q)));

  // R3: the register-file strobe is a single-cycle pulse
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R9: nothing offered during a busy period changes the result pair early
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mul_done && !div_done) |=> ($stable(hi_q) && $stable(lo_q)));

  // R10: a move into lo lands on the accepting edge
  a_r10_setlo: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SETLO) |=> (lo_q == $past(in_a)));
endmodule

// File: tb/sim_mdu_core.sv
`timescale 1ns/1ps
module sim_mdu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = 4'd0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        busy, stall, rd_valid;
  logic [31:0] hi, lo, rd_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] mhi = '0, mlo = '0;

  localparam int LAT = 2;

  always #2 clk = ~clk;

  mdu_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .busy(busy), .stall(stall),
    .hi(hi), .lo(lo), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                           input bit s);
    longint x, y;
    if (s) begin
      x = longint'($signed(a));
      y = longint'($signed(b));
      return 64'(x * y);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  function automatic int ref_iters(input logic [31:0] a, input bit s);
    longint x;
    if (s) begin
      x = longint'($signed(a));
      if (x >= -128 && x <= 127) return 9;
      if (x >= -32768 && x <= 32767) return 17;
      if (x >= -8388608 && x <= 8388607) return 25;
      return 32;
    end
    if (a < 32'h100) return 9;
    if (a < 32'h10000) return 17;
    if (a < 32'h1000000) return 25;
    return 32;
  endfunction

  // issue one operation and check latency and results
  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p, acc;
    logic [31:0] ehi, elo, erd;
    int elat, cnt;
    bit is_rd;
    string req;
    longint x, y;
    ehi = mhi; elo = mlo; erd = '0; is_rd = 0; elat = LAT;
    acc = {mhi, mlo};
    case (op)
      4'd0, 4'd1: begin p = ref_prod(a, b, op == 4'd0); {ehi, elo} = p; req = "R2"; end
      4'd2, 4'd3: begin p = ref_prod(a, b, op == 4'd2); {ehi, elo} = acc + p; req = "R4"; end
      4'd4, 4'd5: begin p = ref_prod(a, b, op == 4'd4); {ehi, elo} = acc - p; req = "R5"; end
      4'd6: begin p = ref_prod(a, b, 1); erd = p[31:0]; is_rd = 1; req = "R3"; end
      default: begin
        elat = ref_iters(a, op == 4'd7);
        req = (b == 0) ? "R8" : "R6";
        if (b == 0) begin elo = '1; ehi = a; end
        else if (op == 4'd7) begin
          x = longint'($signed(a)); y = longint'($signed(b));
          elo = 32'(x / y); ehi = 32'(x % y);
        end else begin
          elo = a / b; ehi = a % b;
        end
      end
    endcase
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 64) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == elat, (op >= 4'd7) ? "R7 busy length" : "R2 busy length",
        64'(cnt), 64'(elat));
    chk(hi == ehi && lo == elo, req, {hi, lo}, {ehi, elo});
    if (is_rd) chk(rd_valid == 1'b1 && rd_data == erd, "R3 rd port", {31'b0, rd_valid, rd_data},
                   {32'd1, erd});
    else chk(rd_valid == 1'b0, "R3 no rd strobe", {63'b0, rd_valid}, 64'd0);
    mhi = ehi; mlo = elo;
  endtask

  task automatic do_move(input logic [3:0] op, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a;
    @(negedge clk);
    in_valid = 1'b0;
    if (op == 4'd9) mhi = a; else mlo = a;
    chk(busy == 1'b0 && hi == mhi && lo == mlo, "R10 move", {hi, lo}, {mhi, mlo});
  endtask

  logic [31:0] vals [12];

  initial begin
    vals[0] = 32'd0;          vals[1] = 32'd1;          vals[2] = 32'd7;
    vals[3] = 32'hFFFFFFFF;   vals[4] = 32'hFFFFFFF9;   vals[5] = 32'd127;
    vals[6] = 32'hFFFFFF80;   vals[7] = 32'd300;        vals[8] = 32'hFFFF63C0;
    vals[9] = 32'h00ABCDEF;   vals[10] = 32'h7FFFFFFF;  vals[11] = 32'h80000000;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hi == 0 && lo == 0, "R1 hi/lo", {hi, lo}, 64'd0);
    chk(!busy && !stall && !rd_valid, "R1 flags", {61'b0, busy, stall, rd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_move(4'd9, 32'hDEADBEEF);
    do_move(4'd10, 32'h01234567);

    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        run_op(4'd0, vals[i], vals[j]);
        run_op(4'd3, vals[j], vals[i]);
        run_op(4'd4, vals[i], vals[j]);
        run_op(4'd1, vals[i], vals[j]);
        run_op(4'd2, vals[i], vals[j]);
        run_op(4'd5, vals[j], vals[i]);
        run_op(4'd6, vals[i], vals[j]);
        run_op(4'd7, vals[i], vals[j]);
        run_op(4'd8, vals[i], vals[j]);
      end
    end

    // R11: unassigned opcodes leave everything alone
    for (int k = 11; k < 16; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_op = 4'(k); in_a = 32'h5A5A5A5A; in_b = 32'd3;
      @(negedge clk);
      in_valid = 1'b0;
      chk(!busy && !rd_valid && hi == mhi && lo == mlo, "R11 ignored opcode",
          {hi, lo}, {mhi, mlo});
    end

    // R9: a move held during a divide waits for it
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd7; in_a = 32'h7FFFFFFF; in_b = 32'd3;
    @(negedge clk);
    in_op = 4'd9; in_a = 32'h0000ABCD;
    chk(stall == 1'b1 && busy == 1'b1, "R9 stall raised", {62'b0, stall, busy}, 64'd3);
    begin
      int cnt;
      cnt = 1;
      @(negedge clk);
      while (busy && cnt < 64) begin
        cnt++;
        chk(stall == 1'b1, "R9 stall held", {63'b0, stall}, 64'd1);
        @(negedge clk);
      end
      chk(cnt == 32, "R9 divide length under stall", 64'(cnt), 64'd32);
    end
    chk(hi == 32'd1 && lo == 32'h2AAAAAAA, "R9 divide result kept", {hi, lo},
        {32'd1, 32'h2AAAAAAA});
    chk(stall == 1'b0, "R9 stall released", {63'b0, stall}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(hi == 32'h0000ABCD && lo == 32'h2AAAAAAA, "R9 held move applied", {hi, lo},
        {32'h0000ABCD, 32'h2AAAAAAA});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule